// File: doc/BRIEF.md
# GPIO Port Interrupt-on-Change Unit

This unit watches one GPIO port (eight pins by default) and raises an interrupt when an enabled pin changes or when it disagrees with a reference level. Each pin is set separately to one of two modes. In change mode the pin fires when its synchronized level differs from the level it had one clock earlier. In compare mode it fires while its level differs from its own reference bit. A reference bit of 0 therefore gives high-level detection, and a reference bit of 1 gives low-level detection.

The first trigger moves a two-state controller from `ST_IDLE` to `ST_PEND`. On that edge the unit records the winning pin in a one-hot flag word and copies the whole port into a capture word. While the controller is in `ST_PEND`, both words stay frozen and new triggers are ignored. The host leaves `ST_PEND` (transition "clear") by reading the port register or by reading the capture register; configuration bit 0 selects which of the two reads counts. The interrupt output is driven push-pull with selectable polarity, or open drain.

The two transitions are "trigger" (`ST_IDLE` to `ST_PEND`, taken when any enabled pin fires) and "clear" (`ST_PEND` to `ST_IDLE`, taken on the selected read strobe). A compare-mode mismatch that still holds after a clear takes the trigger transition again on the next edge.

Top module: `gpio_ioc_unit`

## Requirements
- R1: A pin whose `irq_en` bit is 0 never sets a flag bit or asserts the interrupt, whatever its level does.
- R2: With `cmp_mode[i]`=0 and `irq_en[i]`=1, a change of pin i between two consecutive clock edges sets the flag and asserts the interrupt on the edge that first sees the new level.
- R3: With `cmp_mode[i]`=1 and `irq_en[i]`=1, the interrupt fires while `pin_lvl[i]` differs from `ref_val[i]`. `ref_val[i]`=0 detects a high level, and `ref_val[i]`=1 detects a low level.
- R4: `flag_q` has at most one bit set. When several enabled pins fire on the same edge, the lowest-numbered pin is flagged.
- R5: On the trigger edge, `cap_q` takes the full `pin_lvl` value.
- R6: While an interrupt is pending and no selected clear read occurs, `flag_q` and `cap_q` hold their values.
- R7: With `port_cfg[0]`=0, a cycle with `rd_port`=1 clears the pending interrupt, and `flag_q` becomes 0 after that edge; `rd_cap` has no effect.
- R8: With `port_cfg[0]`=1, a cycle with `rd_cap`=1 clears the pending interrupt; `rd_port` has no effect.
- R9: If a compare-mode mismatch still holds when the interrupt is cleared, the interrupt is pending again one edge after the clearing edge.
- R10: With `port_cfg[2]`=0, `irq_oe`=1 and `irq_drv` equals the pending state when `port_cfg[1]`=1 (active high), and its inverse when `port_cfg[1]`=0 (active low).
- R11: With `port_cfg[2]`=1 (open drain, which overrides `port_cfg[1]`), `irq_drv`=0 and `irq_oe` equals the pending state, so the pin is high impedance when no interrupt is pending.
- R12: After reset, `flag_q` and `cap_q` are 0 and no interrupt is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | WIDTH | Synchronized pin levels |
| irq_en | input | WIDTH | Per-pin interrupt enable |
| cmp_mode | input | WIDTH | Per-pin mode: 0 change, 1 compare to reference |
| ref_val | input | WIDTH | Per-pin reference level for compare mode |
| port_cfg | input | 3 | Bit 0 clear on capture read, bit 1 active-high output, bit 2 open drain |
| rd_cap | input | 1 | Capture register read strobe |
| rd_port | input | 1 | Port register read strobe |
| flag_q | output | WIDTH | One-hot cause of the pending interrupt |
| cap_q | output | WIDTH | Port value captured at the trigger |
| irq_drv | output | 1 | Interrupt pin data level |
| irq_oe | output | 1 | Interrupt pin output enable (0 is high impedance) |

## Verification
The hardest situation to reach from the ports is the re-trigger after a clear: the interrupt must drop for exactly one edge and then return while the reference mismatch persists. The stimulus puts one pin in compare mode with a held mismatch, pulses the port read for a single cycle, and samples the flag once after the clearing edge and once after the following edge. A second hard case is two enabled pins flipping on the same edge while other pins are frozen from an earlier pending interrupt. The stimulus reaches it by clearing first and then flipping both pins in one drive step.

// File: rtl/gpio_ioc_pkg.sv
package gpio_ioc_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } ioc_state_t;

    localparam int CFG_W        = 3;
    localparam int CFG_CLR_CAP  = 0;
    localparam int CFG_POL_HIGH = 1;
    localparam int CFG_OPEN_DRN = 2;
endpackage

// File: rtl/ioc_detect.sv
module ioc_detect #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin,
    input  logic [WIDTH-1:0] en,
    input  logic [WIDTH-1:0] mode,
    input  logic [WIDTH-1:0] refv,
    output logic [WIDTH-1:0] fire
);
    logic [WIDTH-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= '0;
        else        last_q <= pin;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        always_comb begin
            if (mode[i]) fire[i] = en[i] & (pin[i] ^ refv[i]);
            else         fire[i] = en[i] & (pin[i] ^ last_q[i]);
        end
    end
endmodule

// File: rtl/ioc_first_pick.sv
module ioc_first_pick #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] req,
    output logic [WIDTH-1:0] grant
);
    logic [WIDTH:0] seen;

    assign seen[0] = 1'b0;
    for (genvar i = 0; i < WIDTH; i++) begin : g_chain
        assign grant[i]  = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end
endmodule

// File: rtl/ioc_irq_out.sv
module ioc_irq_out (
    input  logic active,
    input  logic pol_high,
    input  logic open_drn,
    output logic drv,
    output logic oe
);
    always_comb begin
        if (open_drn) begin
            drv = 1'b0;
            oe  = active;
        end else begin
            drv = pol_high ? active : ~active;
            oe  = 1'b1;
        end
    end
endmodule

// File: rtl/gpio_ioc_unit.sv
module gpio_ioc_unit
    import gpio_ioc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_lvl,
    input  logic [WIDTH-1:0] irq_en,
    input  logic [WIDTH-1:0] cmp_mode,
    input  logic [WIDTH-1:0] ref_val,
    input  logic [CFG_W-1:0] port_cfg,
    input  logic             rd_cap,
    input  logic             rd_port,
    output logic [WIDTH-1:0] flag_q,
    output logic [WIDTH-1:0] cap_q,
    output logic             irq_drv,
    output logic             irq_oe
);
    ioc_state_t       state_q, state_d;
    logic [WIDTH-1:0] fire;
    logic [WIDTH-1:0] winner;
    logic             any_fire;
    logic             clr_hit;

    ioc_detect #(.WIDTH(WIDTH)) u_detect (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (pin_lvl),
        .en   (irq_en),
        .mode (cmp_mode),
        .refv (ref_val),
        .fire (fire)
    );

    ioc_first_pick #(.WIDTH(WIDTH)) u_pick (
        .req  (fire),
        .grant(winner)
    );

    assign any_fire = |fire;
    assign clr_hit  = port_cfg[CFG_CLR_CAP] ? rd_cap : rd_port;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (any_fire) state_d = ST_PEND;
            ST_PEND: if (clr_hit)  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
            cap_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (any_fire) begin
                        flag_q <= winner;
                        cap_q  <= pin_lvl;
                    end
                end
                ST_PEND: begin
                    if (clr_hit) flag_q <= '0;
                end
                default: flag_q <= '0;
            endcase
        end
    end

    ioc_irq_out u_out (
        .active  (state_q == ST_PEND),
        .pol_high(port_cfg[CFG_POL_HIGH]),
        .open_drn(port_cfg[CFG_OPEN_DRN]),
        .drv     (irq_drv),
        .oe      (irq_oe)
    );
endmodule

// File: rtl/gpio_ioc_checker.sv
module gpio_ioc_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] pin_lvl,
    input logic [WIDTH-1:0] irq_en,
    input logic [2:0]       port_cfg,
    input logic             rd_cap,
    input logic             rd_port,
    input logic [WIDTH-1:0] flag_q,
    input logic [WIDTH-1:0] cap_q,
    input logic             irq_drv,
    input logic             irq_oe
);
    logic pend;
    logic sel_clr;
    assign pend    = (flag_q != '0);
    assign sel_clr = port_cfg[0] ? rd_cap : rd_port;

    assert_enable_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && irq_en == '0) |=> !pend);

    assert_flag_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag_q));

    assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> cap_q == $past(pin_lvl));

    assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !sel_clr) |=> ($stable(flag_q) && $stable(cap_q)));

    assert_port_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !port_cfg[0] && rd_port) |=> !pend);

    assert_cap_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && port_cfg[0] && rd_cap) |=> !pend);

    assert_open_drain_R11: assert property (@(posedge clk) disable iff (!rst_n)
        port_cfg[2] |-> (!irq_drv && irq_oe == pend));
endmodule

bind gpio_ioc_unit gpio_ioc_checker #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_lvl (pin_lvl),
    .irq_en  (irq_en),
    .port_cfg(port_cfg),
    .rd_cap  (rd_cap),
    .rd_port (rd_port),
    .flag_q  (flag_q),
    .cap_q   (cap_q),
    .irq_drv (irq_drv),
    .irq_oe  (irq_oe)
);

// File: tb/gpio_ioc_unit_test.sv
module gpio_ioc_unit_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pin_lvl = '0;
    logic [W-1:0] irq_en = '0;
    logic [W-1:0] cmp_mode = '0;
    logic [W-1:0] ref_val = '0;
    logic [2:0]   port_cfg = '0;
    logic         rd_cap = 1'b0;
    logic         rd_port = 1'b0;
    logic [W-1:0] flag_q;
    logic [W-1:0] cap_q;
    logic         irq_drv;
    logic         irq_oe;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gpio_ioc_unit #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .irq_en(irq_en),
        .cmp_mode(cmp_mode), .ref_val(ref_val), .port_cfg(port_cfg),
        .rd_cap(rd_cap), .rd_port(rd_port), .flag_q(flag_q), .cap_q(cap_q),
        .irq_drv(irq_drv), .irq_oe(irq_oe)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_port();
        rd_port = 1'b1;
        tick();
        rd_port = 1'b0;
    endtask

    task automatic pulse_cap();
        rd_cap = 1'b1;
        tick();
        rd_cap = 1'b0;
    endtask

    task automatic t_reset();
        check("R12 flag after reset", 16'(flag_q), 16'h00);
        check("R12 cap after reset", 16'(cap_q), 16'h00);
        check("R12 irq idle active-low", {14'h0, irq_oe, irq_drv}, 16'h3);
    endtask

    task automatic t_enable();
        irq_en = '0; cmp_mode = '0;
        pin_lvl = 8'hA5; tick();
        pin_lvl = 8'h00; tick();
        check("R1 disabled pins no flag", 16'(flag_q), 16'h00);
        check("R1 disabled pins irq idle", 16'(irq_drv), 16'h1);
    endtask

    task automatic t_change();
        irq_en = 8'hFF; cmp_mode = '0; tick();
        pin_lvl = 8'h10; tick();
        check("R2 change flag", 16'(flag_q), 16'h10);
        check("R5 capture", 16'(cap_q), 16'h10);
        check("R2 irq active low", 16'(irq_drv), 16'h0);
        pin_lvl = 8'h11; tick();
        check("R6 flag frozen", 16'(flag_q), 16'h10);
        check("R6 capture frozen", 16'(cap_q), 16'h10);
        pulse_cap();
        check("R7 capture read ignored", 16'(flag_q), 16'h10);
        pulse_port();
        check("R7 port read clears", 16'(flag_q), 16'h00);
        check("R7 irq released", 16'(irq_drv), 16'h1);
        tick();
        check("R2 no retrigger on static pins", 16'(flag_q), 16'h00);
    endtask

    task automatic t_priority();
        pin_lvl = 8'h35; tick();
        check("R4 lowest pin wins", 16'(flag_q), 16'h04);
        check("R5 capture both pins", 16'(cap_q), 16'h35);
        pulse_port();
        tick();
    endtask

    task automatic t_cap_clear();
        port_cfg = 3'b001;
        pin_lvl = 8'hB5; tick();
        check("R2 pin7 flag", 16'(flag_q), 16'h80);
        pulse_port();
        check("R8 port read ignored", 16'(flag_q), 16'h80);
        pulse_cap();
        check("R8 capture read clears", 16'(flag_q), 16'h00);
        port_cfg = 3'b000;
        tick();
    endtask

    task automatic t_level();
        pin_lvl = 8'h35;
        irq_en = 8'h01; cmp_mode = 8'h01; ref_val = 8'h00;
        tick();
        check("R3 level high fires", 16'(flag_q), 16'h01);
        pulse_port();
        check("R9 cleared for one edge", 16'(flag_q), 16'h00);
        tick();
        check("R9 mismatch reasserts", 16'(flag_q), 16'h01);
        ref_val = 8'h01;
        pulse_port();
        tick();
        check("R3 match stays quiet", 16'(flag_q), 16'h00);
        pin_lvl = 8'h34; tick();
        check("R3 level low fires", 16'(flag_q), 16'h01);
        check("R5 capture level", 16'(cap_q), 16'h34);
        irq_en = '0;
        pulse_port();
        tick();
    endtask

    task automatic t_output();
        irq_en = 8'h01; cmp_mode = 8'h01; ref_val = 8'h00;
        pin_lvl = 8'h01; tick();
        port_cfg = 3'b010; #1;
        check("R10 active high pending", {14'h0, irq_oe, irq_drv}, 16'h3);
        port_cfg = 3'b000; #1;
        check("R10 active low pending", {14'h0, irq_oe, irq_drv}, 16'h2);
        port_cfg = 3'b110; #1;
        check("R11 open drain pending", {14'h0, irq_oe, irq_drv}, 16'h2);
        irq_en = '0;
        pulse_port();
        check("R11 open drain released", {14'h0, irq_oe, irq_drv}, 16'h0);
        port_cfg = 3'b010; #1;
        check("R10 active high idle", {14'h0, irq_oe, irq_drv}, 16'h2);
        port_cfg = 3'b000;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_enable();
        t_change();
        t_priority();
        t_cap_clear();
        t_level();
        t_output();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule